// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding

This block is the read-after-write control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). The decode stage presents its instruction word and a few decoded flags. The block keeps its own shadow copies of the control fields for the instructions in execute, memory and writeback. From these it drives the operand mux selects at the ALU inputs, a store-data select in the memory stage, a decode-stage register-file bypass, and the stall and bubble controls for the front of the pipeline.

Operands are read in decode and results are written in writeback. Because of this, only read-after-write dependences can arise. Most are resolved by forwarding. A consumer that directly follows a load and needs the loaded value in its ALU gets exactly one bubble. A store whose data register was loaded by the instruction just before it does not stall: the loaded value is steered into the store-data path when the store reaches the memory stage.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the instruction in execute reads a register (use flag high) that the non-load instruction in the memory stage writes, that operand's select is 1 (take the execute/memory result). Operand A uses source 1 and operand B uses source 2.
- R2: When only the writeback-stage instruction writes a register read by an execute operand, that select is 2 (take the memory/writeback result). With no match, the select is 0 (register file).
- R3: When both the memory and writeback stages write the same register read by an execute operand, the select is 1.
- R4: A decode instruction whose ALU source (source 1, or source 2 when not a store) equals the destination of a load in execute raises stall_o and bubble_o for exactly one cycle. The execute slot then holds a no-op (both selects 0), and in the next cycle the consumer's select is 2.
- R5: A store (source 2 is the data register) that directly follows a load of its data register raises no stall. fwd_st_o is 1 in the cycle the store is in the memory stage.
- R6: Register 0 never causes a forward, stall or decode bypass.
- R7: A stage whose write enable is low never causes a forward.
- R8: id_byp_a_o and id_byp_b_o are 1 when the decode instruction reads source 1 or source 2 that the writeback instruction writes in the same cycle.
- R9: The destination is bits 15:11 when id_rr_i is 1 and bits 20:16 otherwise. Source 1 is bits 25:21 and source 2 is bits 20:16.
- R10: During and just after reset, all selects are 0 and no stall, bubble or bypass is raised.
- R11: A source whose use flag is low, or an instruction with id_valid_i low, causes no stall and no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_instr_i | input | INSTR_W | Instruction word in decode |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| id_rr_i | input | 1 | Register-register format (selects destination field) |
| id_wen_i | input | 1 | Instruction writes its destination |
| id_load_i | input | 1 | Instruction is a load |
| id_store_i | input | 1 | Instruction is a store |
| id_use_rs1_i | input | 1 | Source 1 is read |
| id_use_rs2_i | input | 1 | Source 2 is read |
| fwd_a_o | output | 2 | ALU operand A select: 0 register file, 1 execute/memory, 2 memory/writeback |
| fwd_b_o | output | 2 | ALU operand B select, same coding |
| fwd_st_o | output | 1 | Memory-stage store data takes the writeback load value |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Load a no-op into decode/execute register |
| id_byp_a_o | output | 1 | Decode source 1 takes the writeback value |
| id_byp_b_o | output | 1 | Decode source 2 takes the writeback value |

## Verification
Stall, bubble and decode bypass depend only on the instruction presented in decode, so they are due in the same cycle it is driven. Operand selects for an instruction are due one clock edge later, once it sits in execute. The store-data select is due two edges later. Each expectation is queued with its due cycle counted from the cycle its instruction was driven. Outputs are sampled 8 ns after the falling edge, well clear of the rising edge. Any expectation left unmatched at the end counts as a failure.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwd_sel_e;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    reg_idx_t rs1;
    reg_idx_t rs2;
    reg_idx_t rd;
    logic     use1;
    logic     use2;
    logic     wen;
    logic     load;
    logic     store;
  } stage_t;

  localparam stage_t STAGE_NOP = '0;

  function automatic logic raw_dep(reg_idx_t src, logic used, reg_idx_t dst, logic wr);
    return used && wr && (src != '0) && (src == dst);
  endfunction
endpackage

// File: rtl/hz_id_decode.sv
module hz_id_decode
  import hz_pkg::*;
#(
  parameter int unsigned INSTR_W   = 32,
  parameter int unsigned RS1_LSB   = 21,
  parameter int unsigned RS2_LSB   = 16,
  parameter int unsigned RD_RR_LSB = 11,
  parameter int unsigned RD_RI_LSB = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  input  logic               rr_i,
  input  logic               wen_i,
  input  logic               load_i,
  input  logic               store_i,
  input  logic               use_rs1_i,
  input  logic               use_rs2_i,
  output stage_t             stage_o
);
  logic unused_instr;
  assign unused_instr = ^instr_i;

  always_comb begin
    stage_o = STAGE_NOP;
    if (valid_i) begin
      stage_o.rs1   = instr_i[RS1_LSB +: REG_AW];
      stage_o.rs2   = instr_i[RS2_LSB +: REG_AW];
      stage_o.rd    = rr_i ? instr_i[RD_RR_LSB +: REG_AW] : instr_i[RD_RI_LSB +: REG_AW];
      stage_o.use1  = use_rs1_i;
      stage_o.use2  = use_rs2_i;
      stage_o.wen   = wen_i;
      stage_o.load  = load_i;
      stage_o.store = store_i;
    end
  end
endmodule

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stall_i,
  input  stage_t id_stage_i,
  output stage_t stage_o [DEPTH]
);
  stage_t stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      // bubble replaces the decode instruction while the front is held
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stage_q[g] <= STAGE_NOP;
        else if (stall_i) stage_q[g] <= STAGE_NOP;
        else              stage_q[g] <= id_stage_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= STAGE_NOP;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
    assign stage_o[g] = stage_q[g];
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  stage_t   ex_i,
  input  stage_t   mem_i,
  input  stage_t   wb_i,
  output fwd_sel_e op_sel_o [NUM_OPS],
  output logic     st_wb_o
);
  reg_idx_t src  [NUM_OPS];
  logic     used [NUM_OPS];
  logic     mem_avail;

  assign src[0]  = ex_i.rs1;
  assign used[0] = ex_i.use1;
  assign src[1]  = ex_i.rs2;
  assign used[1] = ex_i.use2;

  // a load result does not exist until writeback
  assign mem_avail = mem_i.wen && !mem_i.load;

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    always_comb begin
      if (raw_dep(src[o], used[o], mem_i.rd, mem_avail))  op_sel_o[o] = SEL_EXMEM;
      else if (raw_dep(src[o], used[o], wb_i.rd, wb_i.wen)) op_sel_o[o] = SEL_MEMWB;
      else                                                  op_sel_o[o] = SEL_RF;
    end
  end

  assign st_wb_o = mem_i.store && wb_i.load &&
                   raw_dep(mem_i.rs2, mem_i.use2, wb_i.rd, wb_i.wen);

  logic unused_fields;
  assign unused_fields = ^{ex_i, mem_i, wb_i};
endmodule

// File: rtl/hz_id_ctl.sv
module hz_id_ctl
  import hz_pkg::*;
(
  input  stage_t id_i,
  input  stage_t ex_i,
  input  stage_t wb_i,
  output logic   stall_o,
  output logic   byp_o [NUM_OPS]
);
  reg_idx_t src  [NUM_OPS];
  logic     used [NUM_OPS];
  logic     alu_use [NUM_OPS];
  logic     hit [NUM_OPS];

  assign src[0]     = id_i.rs1;
  assign used[0]    = id_i.use1;
  assign alu_use[0] = id_i.use1;
  assign src[1]     = id_i.rs2;
  assign used[1]    = id_i.use2;
  // store data is fed later in the memory stage, not through the ALU
  assign alu_use[1] = id_i.use2 && !id_i.store;

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    assign hit[o]   = raw_dep(src[o], alu_use[o], ex_i.rd, ex_i.wen && ex_i.load);
    assign byp_o[o] = raw_dep(src[o], used[o], wb_i.rd, wb_i.wen);
  end

  always_comb begin
    stall_o = 1'b0;
    for (int o = 0; o < NUM_OPS; o++) stall_o = stall_o | hit[o];
  end

  logic unused_fields;
  assign unused_fields = ^{id_i, ex_i, wb_i};
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned INSTR_W   = 32,
  parameter int unsigned RS1_LSB   = 21,
  parameter int unsigned RS2_LSB   = 16,
  parameter int unsigned RD_RR_LSB = 11,
  parameter int unsigned RD_RI_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] id_instr_i,
  input  logic               id_valid_i,
  input  logic               id_rr_i,
  input  logic               id_wen_i,
  input  logic               id_load_i,
  input  logic               id_store_i,
  input  logic               id_use_rs1_i,
  input  logic               id_use_rs2_i,
  output logic [1:0]         fwd_a_o,
  output logic [1:0]         fwd_b_o,
  output logic               fwd_st_o,
  output logic               stall_o,
  output logic               bubble_o,
  output logic               id_byp_a_o,
  output logic               id_byp_b_o
);
  localparam int unsigned TRACK_DEPTH = 3;
  localparam int unsigned EX_IDX  = 0;
  localparam int unsigned MEM_IDX = 1;
  localparam int unsigned WB_IDX  = 2;

  stage_t   id_stage;
  stage_t   trk [TRACK_DEPTH];
  fwd_sel_e op_sel [NUM_OPS];
  logic     byp [NUM_OPS];
  logic     stall;
  logic     st_wb;

  hz_id_decode #(
    .INSTR_W  (INSTR_W),
    .RS1_LSB  (RS1_LSB),
    .RS2_LSB  (RS2_LSB),
    .RD_RR_LSB(RD_RR_LSB),
    .RD_RI_LSB(RD_RI_LSB)
  ) u_dec (
    .instr_i  (id_instr_i),
    .valid_i  (id_valid_i),
    .rr_i     (id_rr_i),
    .wen_i    (id_wen_i),
    .load_i   (id_load_i),
    .store_i  (id_store_i),
    .use_rs1_i(id_use_rs1_i),
    .use_rs2_i(id_use_rs2_i),
    .stage_o  (id_stage)
  );

  hz_stage_track #(.DEPTH(TRACK_DEPTH)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall),
    .id_stage_i(id_stage),
    .stage_o   (trk)
  );

  hz_id_ctl u_idc (
    .id_i   (id_stage),
    .ex_i   (trk[EX_IDX]),
    .wb_i   (trk[WB_IDX]),
    .stall_o(stall),
    .byp_o  (byp)
  );

  hz_fwd_sel u_fwd (
    .ex_i    (trk[EX_IDX]),
    .mem_i   (trk[MEM_IDX]),
    .wb_i    (trk[WB_IDX]),
    .op_sel_o(op_sel),
    .st_wb_o (st_wb)
  );

  assign fwd_a_o    = op_sel[0];
  assign fwd_b_o    = op_sel[1];
  assign fwd_st_o   = st_wb;
  assign stall_o    = stall;
  assign bubble_o   = stall;
  assign id_byp_a_o = byp[0];
  assign id_byp_b_o = byp[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned RS1_LSB = 21,
  parameter int unsigned RS2_LSB = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] id_instr_i,
  input logic               id_valid_i,
  input logic               id_use_rs1_i,
  input logic               id_use_rs2_i,
  input logic [1:0]         fwd_a_o,
  input logic [1:0]         fwd_b_o,
  input logic               stall_o,
  input logic               id_byp_a_o,
  input logic               id_byp_b_o
);
  logic rs1_zero, rs2_zero;
  assign rs1_zero = (id_instr_i[RS1_LSB +: 5] == 5'd0);
  assign rs2_zero = (id_instr_i[RS2_LSB +: 5] == 5'd0);

  AST_SINGLE_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o); // R4
  AST_BUBBLE_IS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0)); // R4
  AST_SEL_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'd3) && (fwd_b_o != 2'd3)); // R3
  AST_ZERO_NO_BYPASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs1_zero |-> !id_byp_a_o); // R6
  AST_ZERO_NO_BYPASS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs2_zero |-> !id_byp_b_o); // R6
  AST_ZERO_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_zero && rs2_zero) |-> !stall_o); // R6
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_valid_i || (!id_use_rs1_i && !id_use_rs2_i)) |-> !stall_o); // R11
  AST_IDLE_NO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!id_byp_a_o && !id_byp_b_o)); // R11
endmodule

bind hazard_fwd_unit hz_checker #(
  .INSTR_W(INSTR_W),
  .RS1_LSB(RS1_LSB),
  .RS2_LSB(RS2_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_instr_i  (id_instr_i),
  .id_valid_i  (id_valid_i),
  .id_use_rs1_i(id_use_rs1_i),
  .id_use_rs2_i(id_use_rs2_i),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .stall_o     (stall_o),
  .id_byp_a_o  (id_byp_a_o),
  .id_byp_b_o  (id_byp_b_o)
);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  localparam int K_A = 0, K_B = 1, K_ST = 2, K_STALL = 3, K_BUB = 4, K_BA = 5, K_BB = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] id_instr_i = '0;
  logic        id_valid_i = 1'b0, id_rr_i = 1'b0, id_wen_i = 1'b0, id_load_i = 1'b0;
  logic        id_store_i = 1'b0, id_use_rs1_i = 1'b0, id_use_rs2_i = 1'b0;
  logic [1:0]  fwd_a_o, fwd_b_o;
  logic        fwd_st_o, stall_o, bubble_o, id_byp_a_o, id_byp_b_o;

  always #10 clk = ~clk;

  hazard_fwd_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .id_instr_i(id_instr_i), .id_valid_i(id_valid_i),
    .id_rr_i(id_rr_i), .id_wen_i(id_wen_i), .id_load_i(id_load_i), .id_store_i(id_store_i),
    .id_use_rs1_i(id_use_rs1_i), .id_use_rs2_i(id_use_rs2_i), .fwd_a_o(fwd_a_o),
    .fwd_b_o(fwd_b_o), .fwd_st_o(fwd_st_o), .stall_o(stall_o), .bubble_o(bubble_o),
    .id_byp_a_o(id_byp_a_o), .id_byp_b_o(id_byp_b_o)
  );

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  function automatic int observe(int kind);
    case (kind)
      K_A:     return int'(fwd_a_o);
      K_B:     return int'(fwd_b_o);
      K_ST:    return int'(fwd_st_o);
      K_STALL: return int'(stall_o);
      K_BUB:   return int'(bubble_o);
      K_BA:    return int'(id_byp_a_o);
      default: return int'(id_byp_b_o);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int kind, int dc, int val, string tag);
    exp_t e;
    e.cyc = cyc + dc; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare due expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          check(q[i].tag, observe(q[i].kind), q[i].val);
          q.delete(i);
        end
      end
    end
  end

  task automatic drive(logic [4:0] s1, logic [4:0] s2, logic [4:0] d, logic rr, logic wen,
                       logic ld, logic st, logic u1, logic u2);
    @(negedge clk);
    cyc++;
    id_valid_i   = 1'b1;
    id_rr_i      = rr;
    id_wen_i     = wen;
    id_load_i    = ld;
    id_store_i   = st;
    id_use_rs1_i = u1;
    id_use_rs2_i = u2;
    if (rr) id_instr_i = {6'h00, s1, s2, d, 11'h000};
    else    id_instr_i = {6'h08, s1, (st ? s2 : d), 16'h6800}; // bits 15:11 hold 13
  endtask

  task automatic nop_op();
    @(negedge clk);
    cyc++;
    id_valid_i = 1'b0; id_instr_i = '0; id_wen_i = 1'b0; id_load_i = 1'b0;
    id_store_i = 1'b0; id_use_rs1_i = 1'b0; id_use_rs2_i = 1'b0; id_rr_i = 1'b0;
  endtask

  task automatic rr_op(logic [4:0] s1, logic [4:0] s2, logic [4:0] d);
    drive(s1, s2, d, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask
  task automatic ri_op(logic [4:0] s1, logic [4:0] d);
    drive(s1, 5'd0, d, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic ld_op(logic [4:0] b, logic [4:0] d);
    drive(b, 5'd0, d, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic st_op(logic [4:0] b, logic [4:0] dat);
    drive(b, dat, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask
  task automatic flush();
    for (int i = 0; i < 4; i++) nop_op();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    #5;
    // R10: reset state
    check("R10 fwd_a", int'(fwd_a_o), 0);
    check("R10 fwd_b", int'(fwd_b_o), 0);
    check("R10 stall", int'(stall_o), 0);
    check("R10 fwd_st", int'(fwd_st_o), 0);
    #35 rst_ni = 1'b1;
    nop_op();
    expect_at(K_A, 0, 0, "R10 after reset");
    expect_at(K_BUB, 0, 0, "R10 after reset");
    expect_at(K_BA, 0, 0, "R10 after reset");

    // R1: adjacent ALU producer
    rr_op(2, 3, 5);
    rr_op(5, 6, 7);
    expect_at(K_A, 1, 1, "R1 exmem to A");
    expect_at(K_B, 1, 0, "R1 no match B");
    flush();

    // R2: producer two ahead
    rr_op(1, 1, 8);
    nop_op();
    rr_op(9, 8, 10);
    expect_at(K_B, 1, 2, "R2 memwb to B");
    expect_at(K_A, 1, 0, "R2 no match A");
    flush();

    // R3: both stages write same register
    rr_op(1, 1, 4);
    rr_op(1, 1, 4);
    rr_op(4, 4, 11);
    expect_at(K_A, 1, 1, "R3 younger wins A");
    expect_at(K_B, 1, 1, "R3 younger wins B");
    flush();

    // R9: immediate-form destination is bits 20:16, not 15:11 (which hold 13)
    ri_op(1, 12);
    rr_op(12, 13, 14);
    expect_at(K_A, 1, 1, "R9 ri dest forwarded");
    expect_at(K_B, 1, 0, "R9 bits 15:11 ignored");
    flush();

    // R7: write enable low
    drive(1, 1, 15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rr_op(15, 15, 16);
    expect_at(K_A, 1, 0, "R7 no wen no fwd A");
    expect_at(K_B, 1, 0, "R7 no wen no fwd B");
    flush();

    // R6: register 0
    rr_op(1, 1, 0);
    rr_op(0, 0, 17);
    expect_at(K_A, 1, 0, "R6 r0 no fwd A");
    expect_at(K_B, 1, 0, "R6 r0 no fwd B");
    flush();
    ld_op(1, 0);
    rr_op(0, 2, 3);
    expect_at(K_STALL, 0, 0, "R6 r0 no stall");
    flush();

    // R4: load-use on source 1
    ld_op(1, 20);
    rr_op(20, 2, 21);
    expect_at(K_STALL, 0, 1, "R4 stall");
    expect_at(K_BUB, 0, 1, "R4 bubble");
    rr_op(20, 2, 21);
    expect_at(K_STALL, 0, 0, "R4 single bubble");
    expect_at(K_A, 0, 0, "R4 bubble in EX");
    expect_at(K_A, 1, 2, "R4 load value forwarded");
    flush();

    // R4: load-use on source 2
    ld_op(1, 22);
    rr_op(3, 22, 23);
    expect_at(K_STALL, 0, 1, "R4 stall src2");
    rr_op(3, 22, 23);
    expect_at(K_BUB, 0, 0, "R4 single bubble src2");
    expect_at(K_B, 1, 2, "R4 load value forwarded src2");
    flush();

    // R5: store data from preceding load
    ld_op(1, 24);
    st_op(2, 24);
    expect_at(K_STALL, 0, 0, "R5 no stall");
    expect_at(K_ST, 2, 1, "R5 store data fwd");
    expect_at(K_ST, 1, 0, "R5 not yet");
    flush();

    // R11: unused source field matches load destination
    ld_op(1, 25);
    drive(25, 25, 26, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_at(K_STALL, 0, 0, "R11 unused source no stall");
    expect_at(K_A, 1, 0, "R11 unused source no fwd");
    flush();
    // R11: invalid decode slot
    ld_op(1, 27);
    nop_op();
    expect_at(K_STALL, 0, 0, "R11 invalid no stall");
    flush();

    // R8: writeback to decode bypass
    rr_op(1, 1, 26);
    nop_op();
    nop_op();
    rr_op(26, 26, 27);
    expect_at(K_BA, 0, 1, "R8 bypass A");
    expect_at(K_BB, 0, 1, "R8 bypass B");
    flush();
    rr_op(1, 1, 0);
    nop_op();
    nop_op();
    rr_op(0, 0, 1);
    expect_at(K_BA, 0, 0, "R6 r0 no bypass A");
    expect_at(K_BB, 0, 0, "R6 r0 no bypass B");
    flush();

    nop_op();
    nop_op();
    while (q.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s never sampled actual=missing expected=%0d", q[0].tag, q[0].val);
      q.delete(0);
    end
    finish_run();
  end
endmodule